// File: doc/BRIEF.md
# Track Jump Counter Controller

This block moves the optical pickup across a chosen number of tracks. A host first sends a move command that picks one of three kinds of move (a plain track jump, a sled move or a repeating jump), the direction, and the top seven bits of the track count. A separate count command then supplies the low eight bits. The move starts when the count command arrives. The block loads the assembled count into a 16-bit remaining-tracks counter and takes one track off for every rising track-crossing edge it accepts.

While the move runs, the block asserts a kick phase for the first half of the tracks and a brake phase for the rest. When the counter reaches zero it pulses a completion flag. A signed track position keeps a running tally of every crossing: up when moving inward, down when moving outward.

For repeating jumps, the block waits a number of servo sample ticks after each completion, then fires the same jump again. The host sets that number. An abort input cancels any move, including one that is armed but not yet started.

Top module: `track_jump_ctrl`

## Requirements
- R1: After reset, kick, brake, done and sled_mode are low, remaining is 0 and track_pos is 0.
- R2: A move command is accepted when cmd_code is 0x05 (track jump), 0x06 (sled move) or 0x07 (repeat jump). It arms a pending move: bit 7 of cmd_arg is the direction (0 outward, 1 inward) and bits 6:0 are the upper count. No motion starts yet.
- R3: A count command (cmd_code 0x0B) that arrives while a move is armed starts the move. In the next cycle, remaining equals {1'b0, upper[6:0], cmd_arg[7:0]}, jump_dir shows the armed direction and kick is high.
- R4: A count command with no armed move is ignored: kick stays low and remaining is unchanged.
- R5: During a move, each accepted rising edge of tzc_in lowers remaining by one. It also moves track_pos by +1 for an inward move or by -1 for an outward move.
- R6: tzc_in passes through a two-flop synchronizer. After that, a level held for only one clock is discarded, and a level held for two clocks or more is accepted.
- R7: kick is high while remaining is greater than floor(loaded count / 2). brake is high while remaining is nonzero and no greater than that value.
- R8: When remaining reaches zero, done is high for exactly one cycle and kick and brake drop.
- R9: sled_mode is high only while a move started by command 0x06 is active.
- R10: abort clears kick, brake and remaining in the next cycle and raises no done. It also drops any armed move, so a count command that follows is ignored.
- R11: After a repeat jump completes with rpt_div nonzero, the same count is reloaded and kick rises on the rpt_div-th fs_tick. With rpt_div equal to 0 there is no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code |
| cmd_arg | input | 8 | Command argument byte |
| abort | input | 1 | Cancel any move |
| tzc_in | input | 1 | Asynchronous track-crossing level |
| fs_tick | input | 1 | One pulse per servo sample |
| rpt_div | input | 16 | Sample ticks between repeat jumps, 0 disables |
| kick | output | 1 | Acceleration phase active |
| brake | output | 1 | Deceleration phase active |
| done | output | 1 | One-cycle completion pulse |
| jump_dir | output | 1 | Direction of current move, 1 inward |
| sled_mode | output | 1 | Current move is a sled move |
| remaining | output | 16 | Tracks left to cross |
| track_pos | output | 16 | Running signed track position |

## Verification
The counting path is exercised with inward and outward moves of even and odd length. A length of four shows where the kick phase hands over to brake, and a length of two shows that the handover can come on the very first crossing. Single-clock and two-clock pulses on tzc_in separate a filter that rejects one-cycle glitches from one that rejects everything, or accepts everything. The command ordering is probed with an unarmed count command, a large count, an abort that is followed by a count command, and a repeating jump with nonzero and zero spacing. Together these show that a restart happens only on the exact tick and only when the spacing is enabled.

// File: rtl/tjc_pkg.sv
package tjc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_KICK, ST_BRAKE, ST_WAIT} tjc_state_e;
  typedef enum logic [1:0] {K_NONE, K_TRACK, K_SLED, K_REPEAT} tjc_kind_e;
  localparam logic [7:0] OP_TRACK  = 8'h05;
  localparam logic [7:0] OP_SLED   = 8'h06;
  localparam logic [7:0] OP_REPEAT = 8'h07;
  localparam logic [7:0] OP_COUNT  = 8'h0B;
endpackage

// File: rtl/tjc_zc_filter.sv
module tjc_zc_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_in,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] chain;
  logic held, filt;
  logic s_last;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= zc_in;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
    end
  end

  assign s_last = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= 1'b0;
      filt   <= 1'b0;
      edge_o <= 1'b0;
    end else begin
      held   <= s_last;
      edge_o <= (s_last == held) && s_last && !filt;
      if (s_last == held) filt <= s_last;
    end
  end

  // R6: an accepted edge is never followed by another in the next cycle
  assert_edge_isolated_R6: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tjc_interval.sv
module tjc_interval #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             expire
);
  logic [DIV_W-1:0] ivl;

  always_ff @(posedge clk) begin
    if (rst || !run) ivl <= '0;
    else if (tick)   ivl <= ivl + 1'b1;
  end

  assign expire = run && tick && (div != '0) && (ivl == div - 1'b1);
endmodule

// File: rtl/track_jump_ctrl.sv
module track_jump_ctrl
  import tjc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int UP_W   = 7,
  parameter int LO_W   = 8,
  parameter int DIV_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [7:0]       cmd_arg,
  input  logic             abort,
  input  logic             tzc_in,
  input  logic             fs_tick,
  input  logic [DIV_W-1:0] rpt_div,
  output logic             kick,
  output logic             brake,
  output logic             done,
  output logic             jump_dir,
  output logic             sled_mode,
  output logic [CNT_W-1:0] remaining,
  output logic [CNT_W-1:0] track_pos
);
  localparam int PAD_W = CNT_W - UP_W - LO_W;

  tjc_state_e state;
  tjc_kind_e  kind, pend_kind;
  logic             armed, pend_dir;
  logic [UP_W-1:0]  pend_up;
  logic [CNT_W-1:0] target, half_q;
  logic             zc_edge, expire;
  logic             is_move, is_count, load;
  logic [CNT_W-1:0] tgt_next;

  tjc_zc_filter #(.SYNC_STAGES(SYNC_N)) u_filt (
    .clk(clk), .rst(rst), .zc_in(tzc_in), .edge_o(zc_edge));

  tjc_interval #(.DIV_W(DIV_W)) u_ivl (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .tick(fs_tick),
    .div(rpt_div), .expire(expire));

  assign is_move  = cmd_valid && (cmd_code == OP_TRACK || cmd_code == OP_SLED ||
                                  cmd_code == OP_REPEAT);
  assign is_count = cmd_valid && (cmd_code == OP_COUNT);
  assign load     = is_count && armed;
  assign tgt_next = {{PAD_W{1'b0}}, pend_up, cmd_arg[LO_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; kind <= K_NONE; pend_kind <= K_NONE;
      armed <= 1'b0; pend_dir <= 1'b0; pend_up <= '0;
      target <= '0; half_q <= '0; remaining <= '0; track_pos <= '0;
      jump_dir <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        state <= ST_IDLE; armed <= 1'b0; remaining <= '0;
      end else if (load) begin
        target    <= tgt_next;
        half_q    <= tgt_next >> 1;
        remaining <= tgt_next;
        jump_dir  <= pend_dir;
        kind      <= pend_kind;
        armed     <= 1'b0;
        state     <= (tgt_next == '0) ? ST_IDLE : ST_KICK;
        done      <= (tgt_next == '0);
      end else begin
        if (is_move) begin
          armed     <= 1'b1;
          pend_dir  <= cmd_arg[7];
          pend_up   <= cmd_arg[UP_W-1:0];
          pend_kind <= tjc_kind_e'(cmd_code[1:0]);
        end
        case (state)
          ST_KICK, ST_BRAKE: if (zc_edge) begin
            remaining <= remaining - 1'b1;
            track_pos <= jump_dir ? track_pos + 1'b1 : track_pos - 1'b1;
            if (remaining == {{(CNT_W-1){1'b0}}, 1'b1}) begin
              done  <= 1'b1;
              state <= (kind == K_REPEAT && rpt_div != '0) ? ST_WAIT : ST_IDLE;
            end else if (remaining - 1'b1 <= half_q) begin
              state <= ST_BRAKE;
            end
          end
          ST_WAIT: begin
            if (rpt_div == '0) state <= ST_IDLE;
            else if (expire) begin
              remaining <= target;
              state     <= ST_KICK;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign kick      = (state == ST_KICK);
  assign brake     = (state == ST_BRAKE);
  assign sled_mode = (kind == K_SLED) && (state == ST_KICK || state == ST_BRAKE);

  // R5: while a move runs, the count moves by at most one track per cycle
  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_KICK || state == ST_BRAKE) && !abort && !is_count)
    |=> (remaining == $past(remaining) || remaining == $past(remaining) - 1'b1));
  // R8: completion only with an empty count
  assert_done_empty_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (remaining == '0 && !kick && !brake));
  // R7: braking happens only in the second half of the move
  assert_brake_half_R7: assert property (@(posedge clk) disable iff (rst)
    brake |-> (remaining != '0 && remaining <= half_q));
  // R10: abort ends every phase in the next cycle
  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!kick && !brake && remaining == '0));
  // R11: a zero spacing leaves the wait state without restarting
  assert_no_repeat_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && rpt_div == '0 && !abort && !cmd_valid) |=> state == ST_IDLE);
endmodule

// File: tb/sim_track_jump_ctrl.sv
module sim_track_jump_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, abort = 1'b0, tzc_in = 1'b0, fs_tick = 1'b0;
  logic [7:0] cmd_code = '0, cmd_arg = '0;
  logic [15:0] rpt_div = '0;
  logic kick, brake, done, jump_dir, sled_mode;
  logic [15:0] remaining, track_pos;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [15:0] exp_done_q[$];
  logic [15:0] exp_pos = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  track_jump_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_arg(cmd_arg), .abort(abort), .tzc_in(tzc_in), .fs_tick(fs_tick),
    .rpt_div(rpt_div), .kick(kick), .brake(brake), .done(done),
    .jump_dir(jump_dir), .sled_mode(sled_mode), .remaining(remaining),
    .track_pos(track_pos));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] code, input logic [7:0] arg);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = code; cmd_arg = arg;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic pulse(input int width, input bit counted, input bit inward, input bit last);
    if (counted) exp_pos = inward ? exp_pos + 16'd1 : exp_pos - 16'd1;
    if (last) exp_done_q.push_back(exp_pos);
    @(negedge clk); tzc_in = 1'b1;
    repeat (width) @(negedge clk);
    tzc_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); fs_tick = 1'b1;
    @(negedge clk); fs_tick = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  // scoreboard monitor: each done pulse must match an expected position
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_done_q.size() == 0) check(1'b0, "R8/R10 unexpected done", 1, 0);
      else begin
        logic [15:0] e;
        e = exp_done_q.pop_front();
        check(track_pos == e, "R8 done position", track_pos, e);
        check(remaining == 16'd0, "R8 done remaining", remaining, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog timeout");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!kick && !brake && !done && !sled_mode, "R1 phases", {kick, brake, done}, 0);
    check(remaining == 0 && track_pos == 0, "R1 counters", remaining, 0);

    // R4 unarmed count command
    send(8'h0B, 8'h05);
    check(!kick && remaining == 0, "R4 unarmed count", remaining, 0);

    // R2/R3 inward jump of 4
    send(8'h05, 8'h80);
    check(!kick && remaining == 0, "R2 armed only", kick, 0);
    send(8'h0B, 8'h04);
    check(remaining == 16'd4 && kick, "R3 load", remaining, 4);
    check(jump_dir == 1'b1, "R2 direction inward", jump_dir, 1);
    pulse(2, 1, 1, 0);
    check(remaining == 16'd3 && kick, "R5/R7 first edge kick", remaining, 3);
    check(track_pos == exp_pos, "R5 inward position", track_pos, exp_pos);
    pulse(2, 1, 1, 0);
    check(remaining == 16'd2 && brake && !kick, "R7 brake at half", remaining, 2);
    pulse(2, 1, 1, 0);
    check(remaining == 16'd1 && brake, "R7 brake continues", remaining, 1);
    pulse(2, 1, 1, 1);
    check(!kick && !brake && remaining == 0, "R8 phases cleared", {kick, brake}, 0);

    // R6 glitch filtering, outward jump of 3
    send(8'h05, 8'h00);
    send(8'h0B, 8'h03);
    check(jump_dir == 1'b0, "R2 direction outward", jump_dir, 0);
    pulse(1, 0, 0, 0);
    check(remaining == 16'd3, "R6 one-clock glitch ignored", remaining, 3);
    pulse(2, 1, 0, 0);
    check(remaining == 16'd2 && kick, "R6 two-clock pulse counted", remaining, 2);
    check(track_pos == exp_pos, "R5 outward position", track_pos, exp_pos);

    // R10 abort, then the count command is ignored
    do_abort();
    check(!kick && !brake && remaining == 0, "R10 abort clears", remaining, 0);
    send(8'h0B, 8'h05);
    check(!kick && remaining == 0, "R10 pending dropped", remaining, 0);

    // R9 sled move of 2
    send(8'h06, 8'h00);
    send(8'h0B, 8'h02);
    check(sled_mode == 1'b1, "R9 sled mode on", sled_mode, 1);
    pulse(2, 1, 0, 0);
    check(brake && remaining == 16'd1, "R7 early brake", remaining, 1);
    pulse(2, 1, 0, 1);
    check(sled_mode == 1'b0, "R9 sled mode off", sled_mode, 0);

    // R3 large count
    send(8'h05, 8'h92);
    send(8'h0B, 8'h34);
    check(remaining == 16'h1234, "R3 full count assembly", remaining, 16'h1234);
    do_abort();

    // R11 repeat with spacing 3
    rpt_div = 16'd3;
    send(8'h07, 8'h80);
    send(8'h0B, 8'h02);
    pulse(2, 1, 1, 0);
    pulse(2, 1, 1, 1);
    check(!kick, "R11 waiting", kick, 0);
    tick(); tick();
    check(!kick, "R11 no early restart", kick, 0);
    tick();
    check(kick && remaining == 16'd2, "R11 restart on tick", remaining, 2);
    pulse(2, 1, 1, 0);
    pulse(2, 1, 1, 1);
    do_abort();
    tick(); tick(); tick(); tick();
    check(!kick && remaining == 0, "R10 abort stops repeat", remaining, 0);

    // R11 spacing zero disables repeat
    rpt_div = 16'd0;
    send(8'h07, 8'h80);
    send(8'h0B, 8'h01);
    pulse(2, 1, 1, 1);
    tick(); tick(); tick(); tick();
    check(!kick && remaining == 0, "R11 zero spacing", kick, 0);

    repeat (4) @(negedge clk);
    check(exp_done_q.size() == 0, "R8 all completions seen", exp_done_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule